// File: doc/BRIEF.md
# Multi-mode serial port controller

This block is a byte-oriented serial port of the kind found beside small 8-bit processor cores. It has four operating modes, chosen by a two-bit field in its control register. Mode 0 is a half-duplex synchronous shifter: it drives its own shift clock at the system clock divided by 12 or by 4, and moves data over one bidirectional data line. Mode 1 sends and receives asynchronous frames with 8 data bits. Modes 2 and 3 send and receive 9-bit asynchronous frames. In those modes the ninth bit can be used to tag address frames, so that a receiver only wakes up for addresses.

Software reaches the block through a two-address register bus. Address 0 is the control/status register. Address 1 is the data buffer: a read returns the last received byte, and a write loads the transmitter and starts a frame. A one-cycle baud tick input runs at 16 times the asynchronous bit rate. Modes 2 and 3 differ only in their system-level baud source, so they behave identically here. Hardware sets the transmit-done and receive-done flags, and only a software write clears them.

Top module: `serial_port_core`

## Requirements
- R1: Control register (address 0) layout: bits 7:6 mode, bit 5 multiprocessor/clock-select bit (MP), bit 4 receive enable, bit 3 transmit ninth bit, bit 2 received ninth bit, bit 1 transmit-done flag, bit 0 receive-done flag. All bits reset to 0. A read of address 1 returns the receive buffer, and a write to address 1 starts a transmission in the current mode.
- R2: An asynchronous frame is a start bit (0), 8 data bits LSB first, then in modes 2/3 the transmit ninth bit, then a stop bit (1). Each bit lasts 16 baud ticks, and txd idles high.
- R3: The transmit-done flag is set when an asynchronous transmitter enters the stop bit, or after the 8th bit period in mode 0. It stays set until software writes a 0 to it.
- R4: The asynchronous receiver starts on a falling edge of rxd_in. Each bit is decided by a majority vote of samples at ticks 7, 8 and 9 of the bit. A start bit that is not low at mid-bit is dropped, and the receiver returns to waiting for a new edge.
- R5: An accepted asynchronous frame loads the receive buffer and sets the receive-done flag at mid-stop-bit. The received ninth bit is set to the ninth data bit in modes 2/3, or to the sampled stop bit in mode 1.
- R6: In modes 2/3 with MP=1, a frame whose ninth bit is 0 is dropped: no flag is set, and the buffer and ninth-bit status keep their values.
- R7: In mode 1 with MP=1, a frame with a low stop bit is dropped. With MP=0 it is accepted, and the received ninth bit reads 0.
- R8: A frame that completes while the receive-done flag is still set is dropped. The buffer and the received ninth bit are not overwritten.
- R9: While receive enable is 0, incoming asynchronous frames are ignored.
- R10: A mode 0 transmission drives rxd_oe high and shifts the byte out LSB first on rxd_out. The shift clock period is 12 clocks when MP=0 and 4 clocks when MP=1. The shift clock is low in the first half of each bit and rises at mid-bit, and it idles high.
- R11: In mode 0, a control write with receive enable 1 and receive-done 0 starts an 8-bit reception. The reception samples rxd_in at each rising shift clock edge, LSB first, and sets the receive-done flag at the end. The received ninth bit is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (also the mode 0 oscillator) |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control/status, 1 = data buffer |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| baud_tick | input | 1 | One-cycle pulse at 16x the async bit rate |
| txd | output | 1 | Asynchronous transmit line |
| rxd_in | input | 1 | Async receive line, mode 0 data input |
| rxd_out | output | 1 | Mode 0 data output |
| rxd_oe | output | 1 | Mode 0 data output enable |
| sclk_out | output | 1 | Mode 0 shift clock |

## Verification
The checker looks at every cycle for these rules:
- Each flag rise is traced to its hardware event or to a software write.
- The receive buffer holds while the receive-done flag is set.
- A filtered address frame never raises the flag.
- No receive completion happens with reception disabled.
- txd and the shift clock idle high.

Frame contents, bit order, majority voting, start-bit rejection, the two shift clock periods and mode 0 reception can only be shown by the bench scenarios. These scenarios drive real serial waveforms and compare the bytes decoded on the pins, and the bytes read back over the bus, against a queue of expected values.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic [1:0] {
    SP_SYNC    = 2'd0,
    SP_ASYNC8  = 2'd1,
    SP_ASYNC9A = 2'd2,
    SP_ASYNC9B = 2'd3
  } sp_mode_e;

  // majority of three oversamples
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Accept rule for a completed async frame. The gating bit is the ninth bit
  // in 9-bit modes and the stop bit in 8-bit mode; both must be 1 under MP.
  function automatic logic rx_keep(input logic mp, input logic gate_bit,
                                   input logic flag_busy);
    if (flag_busy) return 1'b0;
    if (mp) return gate_bit;
    return 1'b1;
  endfunction

  // Serial image of an async frame, bit 0 leaves first
  function automatic logic [10:0] tx_frame(input logic [7:0] d,
                                           input logic nine_en,
                                           input logic nine_v);
    return {1'b1, (nine_en ? nine_v : 1'b1), d, 1'b0};
  endfunction

  // Index of the stop bit inside a frame
  function automatic logic [3:0] frame_last(input logic nine_en);
    return nine_en ? 4'd10 : 4'd9;
  endfunction

endpackage

// File: rtl/sp_shift0.sv
module sp_shift0 #(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fast,
  input  logic       tx_go,
  input  logic [7:0] tx_byte,
  input  logic       rx_go,
  input  logic       rxd_in,
  output logic       busy,
  output logic       sclk,
  output logic       dout,
  output logic       oe,
  output logic       tx_done,
  output logic       rx_done,
  output logic [7:0] rx_byte
);
  localparam int CW = $clog2(DIV_SLOW + 1);

  logic          is_rx;
  logic [CW-1:0] cnt;
  logic [CW-1:0] per;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  wire [CW-1:0] half     = per >> 1;
  wire          per_end  = (cnt == per - CW'(1));
  wire          sample   = is_rx && (cnt == half - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      is_rx   <= 1'b0;
      cnt     <= '0;
      per     <= CW'(DIV_SLOW);
      bitn    <= '0;
      sh      <= '0;
      tx_done <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
      if (!busy) begin
        if (tx_go || rx_go) begin
          busy  <= 1'b1;
          is_rx <= !tx_go;
          cnt   <= '0;
          bitn  <= '0;
          per   <= fast ? CW'(DIV_FAST) : CW'(DIV_SLOW);
          if (tx_go) sh <= tx_byte;
        end
      end else begin
        if (sample) sh <= {rxd_in, sh[7:1]};
        if (per_end) begin
          cnt <= '0;
          if (!is_rx) sh <= {1'b1, sh[7:1]};
          if (bitn == 3'd7) begin
            busy    <= 1'b0;
            tx_done <= !is_rx;
            rx_done <= is_rx;
          end else begin
            bitn <= bitn + 3'd1;
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign sclk    = busy ? (cnt >= half) : 1'b1;
  assign oe      = busy && !is_rx;
  assign dout    = oe ? sh[0] : 1'b1;
  assign rx_byte = sh;

endmodule

// File: rtl/sp_atx.sv
module sp_atx
  import sp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] din,
  input  logic       nine_en,
  input  logic       nine_v,
  input  logic       tick,
  output logic       busy,
  output logic       txd,
  output logic       stop_begin
);
  localparam int CW = $clog2(OVS);

  logic [10:0]   sh;
  logic [3:0]    idx;
  logic [3:0]    last;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh         <= '1;
      idx        <= '0;
      last       <= 4'd9;
      cnt        <= '0;
      busy       <= 1'b0;
      stop_begin <= 1'b0;
    end else begin
      stop_begin <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy <= 1'b1;
          sh   <= tx_frame(din, nine_en, nine_v);
          idx  <= '0;
          cnt  <= '0;
          last <= frame_last(nine_en);
        end
      end else if (tick) begin
        if (cnt == CW'(OVS - 1)) begin
          cnt <= '0;
          sh  <= {1'b1, sh[10:1]};
          if (idx == last) begin
            busy <= 1'b0;
          end else begin
            idx <= idx + 4'd1;
            if (idx + 4'd1 == last) stop_begin <= 1'b1;
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign txd = busy ? sh[0] : 1'b1;

endmodule

// File: rtl/sp_arx.sv
module sp_arx
  import sp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       nine_en,
  input  logic       tick,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] data_o,
  output logic       nine_o
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2;

  logic [1:0]    sync;
  logic          prev;
  logic          busy;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [1:0]    votes;
  logic [7:0]    sh;
  logic          b9;

  wire       rx_s   = sync[1];
  wire       fall   = prev && !rx_s;
  wire       in_win = (cnt >= CW'(MID - 1)) && (cnt <= CW'(MID + 1));
  wire       decide = (cnt == CW'(MID + 1));
  wire       v      = maj3(votes[1], votes[0], rx_s);
  wire [3:0] last   = frame_last(nine_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync   <= 2'b11;
      prev   <= 1'b1;
      busy   <= 1'b0;
      cnt    <= '0;
      idx    <= '0;
      votes  <= '0;
      sh     <= '0;
      b9     <= 1'b0;
      done   <= 1'b0;
      data_o <= '0;
      nine_o <= 1'b0;
    end else begin
      sync <= {sync[0], rxd};
      prev <= rx_s;
      done <= 1'b0;
      if (!enable) begin
        busy <= 1'b0;
      end else if (!busy) begin
        if (fall) begin
          busy <= 1'b1;
          cnt  <= '0;
          idx  <= '0;
        end
      end else if (tick) begin
        if (in_win) votes <= {votes[0], rx_s};
        if (cnt == CW'(OVS - 1)) begin
          cnt <= '0;
          idx <= idx + 4'd1;
        end else begin
          cnt <= cnt + CW'(1);
        end
        if (decide) begin
          if (idx == 4'd0) begin
            if (v) busy <= 1'b0;
          end else if (idx <= 4'd8) begin
            sh <= {v, sh[7:1]};
          end else if (idx == last) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            data_o <= sh;
            nine_o <= nine_en ? b9 : v;
          end else begin
            b9 <= v;
          end
        end
      end
    end
  end

endmodule

// File: rtl/serial_port_core.sv
module serial_port_core
  import sp_pkg::*;
#(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4,
  parameter int OVS      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       baud_tick,
  output logic       txd,
  input  logic       rxd_in,
  output logic       rxd_out,
  output logic       rxd_oe,
  output logic       sclk_out
);
  logic [1:0] mode_q;
  logic       mp_q, ren_q, tb9_q, rb9_q, ti_q, ri_q;
  logic [7:0] rbuf_q;

  // named internal events
  logic       ctrl_wr, data_wr, is_sync;
  logic       s0_busy, s0_tx_done, s0_rx_done, s0_rx_go, s0_fast;
  logic [7:0] s0_rx_byte;
  logic       atx_busy, atx_stop;
  logic       arx_done, arx_nine;
  logic [7:0] arx_data;
  logic       arx_keep, ri_set, ti_set, rb9_load;
  logic [7:0] rx_byte_in;

  assign ctrl_wr  = bus_we && !bus_addr;
  assign data_wr  = bus_we && bus_addr;
  assign is_sync  = (sp_mode_e'(mode_q) == SP_SYNC);
  assign s0_rx_go = ctrl_wr && (bus_wdata[7:6] == 2'd0) && bus_wdata[4] && !bus_wdata[0];
  assign s0_fast  = ctrl_wr ? bus_wdata[5] : mp_q;

  sp_shift0 #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_shift0 (
    .clk(clk), .rst_n(rst_n), .fast(s0_fast),
    .tx_go(data_wr && is_sync), .tx_byte(bus_wdata),
    .rx_go(s0_rx_go), .rxd_in(rxd_in),
    .busy(s0_busy), .sclk(sclk_out), .dout(rxd_out), .oe(rxd_oe),
    .tx_done(s0_tx_done), .rx_done(s0_rx_done), .rx_byte(s0_rx_byte)
  );

  sp_atx #(.OVS(OVS)) u_atx (
    .clk(clk), .rst_n(rst_n), .go(data_wr && !is_sync), .din(bus_wdata),
    .nine_en(mode_q[1]), .nine_v(tb9_q), .tick(baud_tick),
    .busy(atx_busy), .txd(txd), .stop_begin(atx_stop)
  );

  sp_arx #(.OVS(OVS)) u_arx (
    .clk(clk), .rst_n(rst_n), .enable(ren_q && !is_sync),
    .nine_en(mode_q[1]), .tick(baud_tick), .rxd(rxd_in),
    .done(arx_done), .data_o(arx_data), .nine_o(arx_nine)
  );

  assign arx_keep   = rx_keep(mp_q, arx_nine, ri_q);
  assign rb9_load   = arx_done && arx_keep;
  assign ri_set     = rb9_load || (s0_rx_done && !ri_q);
  assign ti_set     = atx_stop || s0_tx_done;
  assign rx_byte_in = arx_done ? arx_data : s0_rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'd0;
      mp_q   <= 1'b0;
      ren_q  <= 1'b0;
      tb9_q  <= 1'b0;
      rb9_q  <= 1'b0;
      ti_q   <= 1'b0;
      ri_q   <= 1'b0;
      rbuf_q <= '0;
    end else begin
      if (ctrl_wr) begin
        mode_q <= bus_wdata[7:6];
        mp_q   <= bus_wdata[5];
        ren_q  <= bus_wdata[4];
        tb9_q  <= bus_wdata[3];
        rb9_q  <= bus_wdata[2];
        ti_q   <= bus_wdata[1];
        ri_q   <= bus_wdata[0];
      end
      // hardware events win over a same-cycle software write
      if (ti_set)   ti_q   <= 1'b1;
      if (ri_set)   ri_q   <= 1'b1;
      if (rb9_load) rb9_q  <= arx_nine;
      if (ri_set)   rbuf_q <= rx_byte_in;
    end
  end

  assign bus_rdata = bus_addr ? rbuf_q
                              : {mode_q, mp_q, ren_q, tb9_q, rb9_q, ti_q, ri_q};

endmodule

// File: rtl/sp_checker.sv
module sp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_wr,
  input logic [7:0] bus_wdata,
  input logic       ri_q,
  input logic       ti_q,
  input logic       ri_set,
  input logic       ti_set,
  input logic       arx_done,
  input logic       arx_nine,
  input logic [1:0] mode_q,
  input logic       mp_q,
  input logic       ren_q,
  input logic [7:0] rbuf_q,
  input logic       atx_busy,
  input logic       txd,
  input logic       s0_busy,
  input logic       sclk_out
);
  // R5: receive flag rises only from a completion event or a software write
  p_ri_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri_q) |-> $past(ri_set || (ctrl_wr && bus_wdata[0])));

  // R3: transmit flag rises only from a transmit event or a software write
  p_ti_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti_q) |-> $past(ti_set || (ctrl_wr && bus_wdata[1])));

  // R6: filtered address frame never raises the receive flag
  p_mp_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arx_done && mode_q[1] && mp_q && !arx_nine && !ctrl_wr) |=> !$rose(ri_q));

  // R8: buffer frozen while the receive flag is set
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ri_q |=> $stable(rbuf_q));

  // R9: no async completion while reception is disabled
  p_rxen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arx_done |-> ren_q);

  // R2: idle async line is high
  p_txd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !atx_busy |-> txd);

  // R10: idle shift clock is high
  p_sclk_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !s0_busy |-> sclk_out);
endmodule

bind serial_port_core sp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .bus_wdata(bus_wdata),
  .ri_q(ri_q), .ti_q(ti_q), .ri_set(ri_set), .ti_set(ti_set),
  .arx_done(arx_done), .arx_nine(arx_nine), .mode_q(mode_q), .mp_q(mp_q),
  .ren_q(ren_q), .rbuf_q(rbuf_q), .atx_busy(atx_busy), .txd(txd),
  .s0_busy(s0_busy), .sclk_out(sclk_out)
);

// File: tb/sim_serial_port_core.sv
`timescale 1ns/1ps
module sim_serial_port_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       baud_tick = 1'b0;
  logic       txd;
  logic       rxd_in = 1'b1;
  logic       rxd_out, rxd_oe, sclk_out;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct { logic [7:0] d; bit n9; bit b9; } txexp_t;
  txexp_t txq[$];

  serial_port_core u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .baud_tick(baud_tick),
    .txd(txd), .rxd_in(rxd_in), .rxd_out(rxd_out), .rxd_oe(rxd_oe),
    .sclk_out(sclk_out)
  );

  always #4 clk = ~clk;   // 125 MHz

  // 16x tick every 4 clocks -> one bit = 64 clocks
  int tdiv = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == 3);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver for async transmit: push expectation, then start
  task automatic send_tx(input logic [7:0] d, input bit n9, input bit b9);
    txexp_t e;
    e.d = d; e.n9 = n9; e.b9 = b9;
    txq.push_back(e);
    wr(1'b1, d);
    idle(12 * 64);
  endtask

  // drive one async frame into rxd_in
  task automatic drive_rx(input logic [7:0] d, input bit n9, input bit b9,
                          input bit stopv);
    rxd_in = 1'b0; idle(64);
    for (int i = 0; i < 8; i++) begin rxd_in = d[i]; idle(64); end
    if (n9) begin rxd_in = b9; idle(64); end
    rxd_in = stopv; idle(64);
    rxd_in = 1'b1; idle(64);
  endtask

  // monitor: decode async frames on txd and compare with the queue
  initial begin
    txexp_t e;
    logic [7:0] got;
    wait (rst_n);
    forever begin
      @(negedge txd);
      repeat (32) @(negedge clk);
      check("R2 start bit", txd, 0);
      for (int i = 0; i < 8; i++) begin
        repeat (64) @(negedge clk);
        got[i] = txd;
      end
      if (txq.size() == 0) begin
        check("R2 unexpected frame", 1, 0);
      end else begin
        e = txq.pop_front();
        check("R2 data LSB first", got, e.d);
        if (e.n9) begin
          repeat (64) @(negedge clk);
          check("R2 ninth bit", txd, e.b9);
        end
        repeat (64) @(negedge clk);
        check("R2 stop bit", txd, 1);
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int t0, per;
    idle(5);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    rd(1'b0, v); check("R1 ctrl reset", v, 8'h00);
    rd(1'b1, v); check("R1 rxbuf reset", v, 8'h00);
    check("R2 txd idle", txd, 1);
    check("R10 sclk idle", sclk_out, 1);

    // mode 1 transmit
    wr(1'b0, 8'h40);
    send_tx(8'hA5, 0, 0);
    rd(1'b0, v); check("R3 ti set after frame", v & 8'h02, 8'h02);
    idle(200);
    rd(1'b0, v); check("R3 ti held until cleared", v & 8'h02, 8'h02);
    wr(1'b0, 8'h40);
    rd(1'b0, v); check("R3 ti cleared by write", v & 8'h02, 8'h00);

    // modes 2/3 transmit with ninth bit
    wr(1'b0, 8'h88); send_tx(8'h3C, 1, 1);
    wr(1'b0, 8'hC0); send_tx(8'hC3, 1, 0);
    check("R2 all frames seen", txq.size(), 0);

    // mode 1 receive
    wr(1'b0, 8'h50);
    drive_rx(8'h5A, 0, 0, 1);
    rd(1'b0, v); check("R5 ri and stop in rb9", v & 8'h05, 8'h05);
    rd(1'b1, v); check("R5 rx data", v, 8'h5A);
    // overrun
    drive_rx(8'h11, 0, 0, 1);
    rd(1'b1, v); check("R8 buffer kept on overrun", v, 8'h5A);
    // bad stop with MP=0
    wr(1'b0, 8'h54);
    drive_rx(8'h77, 0, 0, 0);
    rd(1'b0, v); check("R7 bad stop accepted mp0 rb9=0", v & 8'h05, 8'h01);
    rd(1'b1, v); check("R7 data mp0", v, 8'h77);
    // bad stop with MP=1
    wr(1'b0, 8'h70);
    drive_rx(8'h88, 0, 0, 0);
    rd(1'b0, v); check("R7 bad stop dropped mp1", v & 8'h01, 8'h00);
    rd(1'b1, v); check("R7 buffer unchanged", v, 8'h77);
    drive_rx(8'h99, 0, 0, 1);
    rd(1'b1, v); check("R7 good stop accepted mp1", v, 8'h99);

    // start bit glitch rejected
    wr(1'b0, 8'h50);
    rxd_in = 1'b0; idle(16); rxd_in = 1'b1; idle(12 * 64);
    rd(1'b0, v); check("R4 glitch rejected", v & 8'h01, 8'h00);
    drive_rx(8'h42, 0, 0, 1);
    rd(1'b1, v); check("R4 frame after glitch", v, 8'h42);

    // receive disabled
    wr(1'b0, 8'h40);
    drive_rx(8'h24, 0, 0, 1);
    rd(1'b0, v); check("R9 no ri when disabled", v & 8'h01, 8'h00);
    rd(1'b1, v); check("R9 buffer unchanged", v, 8'h42);

    // mode 3 multiprocessor filter
    wr(1'b0, 8'hF0);
    drive_rx(8'h13, 1, 0, 1);
    rd(1'b0, v); check("R6 data frame filtered", v & 8'h05, 8'h00);
    rd(1'b1, v); check("R6 buffer unchanged", v, 8'h42);
    drive_rx(8'h31, 1, 1, 1);
    rd(1'b0, v); check("R6 address frame accepted", v & 8'h05, 8'h05);
    rd(1'b1, v); check("R6 address byte", v, 8'h31);
    // mode 2, MP=0, ninth bit 0 stored
    wr(1'b0, 8'h94);
    drive_rx(8'h66, 1, 0, 1);
    rd(1'b0, v); check("R5 ninth bit 0 stored", v & 8'h05, 8'h01);
    rd(1'b1, v); check("R5 mode 2 data", v, 8'h66);

    // mode 0 transmit, slow then fast
    for (int k = 0; k < 2; k++) begin
      logic [7:0] d;
      logic [7:0] got;
      d = (k == 0) ? 8'hB6 : 8'h4D;
      wr(1'b0, (k == 0) ? 8'h00 : 8'h20);
      fork
        wr(1'b1, d);
        begin
          t0 = 0; per = 0;
          for (int i = 0; i < 8; i++) begin
            @(posedge sclk_out);
            if (i > 0) per = cyc - t0;
            t0 = cyc;
            @(negedge clk);
            got[i] = rxd_out;
            if (i == 3) check("R10 oe during shift", rxd_oe, 1);
          end
        end
      join
      check("R10 shift data", got, d);
      check("R10 sclk period", per, (k == 0) ? 12 : 4);
      idle(20);
      rd(1'b0, v); check("R3 ti after mode 0", v & 8'h02, 8'h02);
      check("R10 oe released", rxd_oe, 0);
    end

    // mode 0 receive, fast clock, rb9 preset to 1
    fork
      wr(1'b0, 8'h34);
      begin
        for (int i = 0; i < 8; i++) begin
          @(negedge sclk_out);
          @(negedge clk);
          rxd_in = v[0] ^ 1'b0 ? 1'b0 : 1'b0;
          rxd_in = 8'hE1 >> i;
        end
      end
    join
    idle(20);
    rxd_in = 1'b1;
    rd(1'b0, v); check("R11 ri set, rb9 unchanged", v & 8'h05, 8'h05);
    rd(1'b1, v); check("R11 mode 0 data", v, 8'hE1);
    wr(1'b0, 8'h00);
    idle(20);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule